// File: doc/BRIEF.md
# Coarse-Fine Timestamp Aligner

This block forms absolute hit timestamps for a group of channels by joining a free-running coarse clock counter with a fine interpolation code. The coarse counter runs in every clock cycle and is kept in Gray code. An external delay-line encoder supplies each channel's fine code together with its hit strobe. The delay line and the counter share a clock but are not phase aligned. A hit that lands just after a clock edge can therefore report a fine code from the start of a new period, while the counter still holds the count of the old period. A plain capture would then be one clock period early.

Each channel corrects this with a small state machine and two internal strobes. The fine strobe captures the fine code, a snapshot of the counter and an "early" status flag. The coarse strobe fires one cycle later and fills the coarse register. It takes the live counter, which is now one count ahead, when the status says the fine code fell in the early bins. Otherwise it takes the snapshot. The Gray coarse value is then decoded to binary and placed above the fine bits. The result is held with a valid flag until the channel is cleared.

Channel states: `ST_IDLE` (waiting for a hit), `ST_FINE` (fine code and status latched, coarse choice pending) and `ST_DONE` (timestamp complete and held). The transitions are:
- `ST_IDLE`→`ST_FINE` on a hit with no clear.
- `ST_FINE`→`ST_DONE` unconditionally in the next cycle.
- `ST_DONE`→`ST_IDLE` on clear.
- Any state →`ST_IDLE` on clear, which has priority over everything else.

Top module: `cf_stamp_top`

## Requirements
- R1: A synchronous active-high reset sets the counter to zero, drops every valid flag and sets every timestamp to zero.
- R2: After reset the coarse count increases by exactly one per clock. It is held in Gray code, so successive register values differ in exactly one bit.
- R3: Each channel's timestamp is COARSE_W+FINE_W bits wide. Bits [FINE_W-1:0] hold the captured fine code and the bits above them hold the binary coarse count.
- R4: A hit whose fine code is not below EARLY_BINS (default 2) records the coarse count present at the clock edge that samples the hit.
- R5: A hit whose fine code is below EARLY_BINS records that count plus one, which is the count present one edge later.
- R6: The valid flag is low after the edge that samples the hit and high after the following edge.
- R7: While a channel is in `ST_FINE` or `ST_DONE`, further hits are ignored, and its timestamp and valid flag stay unchanged.
- R8: Clear returns a channel to `ST_IDLE`, so its valid flag is low after the edge that samples clear. A hit in the same cycle as clear is ignored.
- R9: The coarse count wraps modulo 2^COARSE_W, and the early-bin correction wraps with it: a count of all ones plus one gives zero.
- R10: Channels are independent: a hit or clear on one channel does not change another channel's valid flag or timestamp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| hit_i | input | NUM_CH | Per-channel hit strobe, one cycle |
| clr_i | input | NUM_CH | Per-channel clear, releases a held timestamp |
| fine_i | input | NUM_CH*FINE_W | Per-channel fine code, sampled with the hit |
| valid_o | output | NUM_CH | Per-channel timestamp complete |
| ts_o | output | NUM_CH*(COARSE_W+FINE_W) | Per-channel timestamp, channel k at bits [k*TS_W +: TS_W] |

## Verification
The bench targets the fine-code boundary around EARLY_BINS. It hits with codes 0, 1 and 2 and compares the coarse field against a count it models itself. A design with the correction inverted or off by one bin would record N where N+1 is due, or the reverse. It also places an early hit on the last count of a narrow counter. A design whose correction did not wrap would produce a value other than zero there. Finally, it sends hits while a channel is busy or holding, and sends a hit in the same cycle as a clear. A design that re-armed too early would overwrite a held timestamp or start a capture that should have been dropped.

// File: rtl/cfs_pkg.sv
package cfs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FINE = 2'd1,
        ST_DONE = 2'd2
    } chan_state_t;

endpackage

// File: rtl/cfs_gray2bin.sv
module cfs_gray2bin #(
    parameter int W = 48
) (
    input  logic [W-1:0] g_i,
    output logic [W-1:0] b_o
);

    // Each binary bit is the parity of the Gray bits at and above it.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign b_o[i] = ^g_i[W-1:i];
    end

endmodule

// File: rtl/cfs_gray_counter.sv
module cfs_gray_counter #(
    parameter int W = 48
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] gray_o,
    output logic [W-1:0] bin_o
);

    logic [W-1:0] g_q;
    logic [W-1:0] bin_w;
    logic [W-1:0] bin_nx;

    cfs_gray2bin #(.W(W)) u_dec (
        .g_i (g_q),
        .b_o (bin_w)
    );

    assign bin_nx = bin_w + W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            g_q <= '0;
        end else begin
            g_q <= bin_nx ^ (bin_nx >> 1);
        end
    end

    assign gray_o = g_q;
    assign bin_o  = bin_w;

    // Arming flags so that $past only reaches cycles after reset.
    logic seen_rst_q;
    logic armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_rst_q <= 1'b1;
            armed_q    <= 1'b0;
        end else begin
            armed_q    <= seen_rst_q;
        end
    end

    // R1: reset clears the count
    a_r1_count_zero: assert property (@(posedge clk)
        rst |=> (g_q == '0));

    // R2: one Gray bit changes per step
    a_r2_gray_one_bit: assert property (@(posedge clk) disable iff (rst)
        armed_q |-> ($countones(g_q ^ $past(g_q)) == 1));

    // R2: binary view advances by one
    a_r2_bin_step: assert property (@(posedge clk) disable iff (rst)
        armed_q |-> (bin_w == $past(bin_w) + W'(1)));

endmodule

// File: rtl/cfs_channel.sv
module cfs_channel
    import cfs_pkg::*;
#(
    parameter int COARSE_W   = 48,
    parameter int FINE_W     = 5,
    parameter int EARLY_BINS = 2,
    localparam int TS_W      = COARSE_W + FINE_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                hit_i,
    input  logic                clr_i,
    input  logic [FINE_W-1:0]   fine_i,
    input  logic [COARSE_W-1:0] cnt_gray_i,
    input  logic [COARSE_W-1:0] cnt_bin_i,
    output logic                valid_o,
    output logic [TS_W-1:0]     ts_o
);

    chan_state_t state_q;
    chan_state_t state_d;

    logic                stb_fine;
    logic                stb_coarse;
    logic [FINE_W-1:0]   fine_q;
    logic [COARSE_W-1:0] snap_q;
    logic [COARSE_W-1:0] coarse_q;
    logic                early_q;
    logic [COARSE_W-1:0] coarse_bin;

    // Two strobes: one for the fine capture, one for the coarse capture.
    assign stb_fine   = (state_q == ST_IDLE) && hit_i && !clr_i;
    assign stb_coarse = (state_q == ST_FINE) && !clr_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (stb_fine) state_d = ST_FINE;
            ST_FINE: state_d = ST_DONE;
            ST_DONE: state_d = ST_DONE;
            default: state_d = ST_IDLE;
        endcase
        if (clr_i) begin
            state_d = ST_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fine_q   <= '0;
            snap_q   <= '0;
            early_q  <= 1'b0;
            coarse_q <= '0;
        end else begin
            if (stb_fine) begin
                fine_q  <= fine_i;
                snap_q  <= cnt_gray_i;
                early_q <= (fine_i < FINE_W'(EARLY_BINS));
            end
            if (stb_coarse) begin
                // Early bins: the counter has advanced since the hit edge.
                coarse_q <= early_q ? cnt_gray_i : snap_q;
            end
        end
    end

    cfs_gray2bin #(.W(COARSE_W)) u_dec (
        .g_i (coarse_q),
        .b_o (coarse_bin)
    );

    assign valid_o = (state_q == ST_DONE);
    assign ts_o    = {coarse_bin, fine_q};

    // R6: valid rises two edges after the sampled hit
    a_r6_valid_latency: assert property (@(posedge clk) disable iff (rst)
        $rose(valid_o) |-> ($past(hit_i, 2) && !$past(clr_i, 2) && !$past(clr_i, 1)));

    // R7: a held timestamp does not change
    a_r7_hold_stable: assert property (@(posedge clk) disable iff (rst)
        ($past(valid_o) && valid_o) |-> $stable(ts_o));

    // R8: clear drops valid
    a_r8_clear_drops: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> !valid_o);

    // R5: early code credits count N+1 (live count is N+2 here)
    a_r5_early_next: assert property (@(posedge clk) disable iff (rst)
        ($rose(valid_o) && (ts_o[FINE_W-1:0] < FINE_W'(EARLY_BINS)))
            |-> (ts_o[TS_W-1:FINE_W] == cnt_bin_i - COARSE_W'(1)));

    // R4: late code credits count N
    a_r4_late_same: assert property (@(posedge clk) disable iff (rst)
        ($rose(valid_o) && (ts_o[FINE_W-1:0] >= FINE_W'(EARLY_BINS)))
            |-> (ts_o[TS_W-1:FINE_W] == cnt_bin_i - COARSE_W'(2)));

endmodule

// File: rtl/cf_stamp_top.sv
module cf_stamp_top #(
    parameter int NUM_CH     = 4,
    parameter int COARSE_W   = 48,
    parameter int FINE_W     = 5,
    parameter int EARLY_BINS = 2,
    localparam int TS_W      = COARSE_W + FINE_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_CH-1:0]        hit_i,
    input  logic [NUM_CH-1:0]        clr_i,
    input  logic [NUM_CH*FINE_W-1:0] fine_i,
    output logic [NUM_CH-1:0]        valid_o,
    output logic [NUM_CH*TS_W-1:0]   ts_o
);

    logic [COARSE_W-1:0] cnt_gray;
    logic [COARSE_W-1:0] cnt_bin;

    cfs_gray_counter #(.W(COARSE_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .gray_o (cnt_gray),
        .bin_o  (cnt_bin)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        cfs_channel #(
            .COARSE_W   (COARSE_W),
            .FINE_W     (FINE_W),
            .EARLY_BINS (EARLY_BINS)
        ) u_ch (
            .clk        (clk),
            .rst        (rst),
            .hit_i      (hit_i[c]),
            .clr_i      (clr_i[c]),
            .fine_i     (fine_i[c*FINE_W +: FINE_W]),
            .cnt_gray_i (cnt_gray),
            .cnt_bin_i  (cnt_bin),
            .valid_o    (valid_o[c]),
            .ts_o       (ts_o[c*TS_W +: TS_W])
        );
    end

    // R1: reset leaves every channel idle with a zero timestamp
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> ((valid_o == '0) && (ts_o == '0)));

endmodule

// File: tb/test_cf_stamp_top.sv
module test_cf_stamp_top;

    localparam int NCH = 4;
    localparam int CW  = 48;
    localparam int FW  = 5;
    localparam int TW  = CW + FW;
    localparam int NW  = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NCH-1:0]    hit  = '0;
    logic [NCH-1:0]    clr  = '0;
    logic [NCH*FW-1:0] fine = '0;
    logic [NCH-1:0]    valid;
    logic [NCH*TW-1:0] ts;

    logic          n_hit  = 1'b0;
    logic          n_clr  = 1'b0;
    logic [FW-1:0] n_fine = '0;
    logic          n_valid;
    logic [NW+FW-1:0] n_ts;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [CW-1:0] mdl = '0;

    always #2.5 clk = ~clk;

    always @(posedge clk) mdl <= rst ? '0 : mdl + CW'(1);

    cf_stamp_top #(.NUM_CH(NCH), .COARSE_W(CW), .FINE_W(FW), .EARLY_BINS(2)) i_cf_stamp_top (
        .clk (clk), .rst (rst), .hit_i (hit), .clr_i (clr),
        .fine_i (fine), .valid_o (valid), .ts_o (ts)
    );

    cf_stamp_top #(.NUM_CH(1), .COARSE_W(NW), .FINE_W(FW), .EARLY_BINS(2)) i_cf_stamp_top_narrow (
        .clk (clk), .rst (rst), .hit_i (n_hit), .clr_i (n_clr),
        .fine_i (n_fine), .valid_o (n_valid), .ts_o (n_ts)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [TW-1:0] ts_of(input int ch);
        return ts[ch*TW +: TW];
    endfunction

    task automatic do_hit(input int ch, input logic [FW-1:0] f, output logic [CW-1:0] n);
        @(negedge clk);
        hit[ch] = 1'b1;
        fine[ch*FW +: FW] = f;
        n = mdl;
        @(negedge clk);
        hit[ch] = 1'b0;
        chk(valid[ch] == 1'b0, "R6 valid low after hit edge", 64'(valid[ch]), 64'd0);
        @(negedge clk);
        chk(valid[ch] == 1'b1, "R6 valid high one edge later", 64'(valid[ch]), 64'd1);
    endtask

    task automatic do_clear(input int ch);
        @(negedge clk);
        clr[ch] = 1'b1;
        @(negedge clk);
        clr[ch] = 1'b0;
        chk(valid[ch] == 1'b0, "R8 clear drops valid", 64'(valid[ch]), 64'd0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(valid == '0, "R1 valid after reset", 64'(valid), 64'd0);
        for (int c = 0; c < NCH; c++)
            chk(ts_of(c) == '0, "R1 timestamp after reset", 64'(ts_of(c)), 64'd0);
    endtask

    task automatic t_late();
        logic [CW-1:0] n;
        do_hit(0, 5'd17, n);
        chk(ts_of(0) == {n, 5'd17}, "R4 R3 late code keeps count", 64'(ts_of(0)), 64'({n, 5'd17}));
        do_clear(0);
    endtask

    task automatic t_boundary();
        logic [CW-1:0] n;
        do_hit(0, 5'd2, n);
        chk(ts_of(0) == {n, 5'd2}, "R4 code at EARLY_BINS is late", 64'(ts_of(0)), 64'({n, 5'd2}));
        do_clear(0);
        do_hit(0, 5'd1, n);
        chk(ts_of(0) == {n + CW'(1), 5'd1}, "R5 code 1 is early", 64'(ts_of(0)), 64'({n + CW'(1), 5'd1}));
        do_clear(0);
        do_hit(0, 5'd0, n);
        chk(ts_of(0) == {n + CW'(1), 5'd0}, "R5 code 0 gets N+1", 64'(ts_of(0)), 64'({n + CW'(1), 5'd0}));
        do_clear(0);
    endtask

    task automatic t_step();
        logic [CW-1:0] n;
        @(negedge clk);
        n = mdl;
        hit[0] = 1'b1; fine[0 +: FW] = 5'd9;
        @(negedge clk);
        hit[0] = 1'b0;
        hit[1] = 1'b1; fine[FW +: FW] = 5'd9;
        @(negedge clk);
        hit[1] = 1'b0;
        @(negedge clk);
        chk(ts_of(1)[TW-1:FW] - ts_of(0)[TW-1:FW] == CW'(1), "R2 count steps by one",
            64'(ts_of(1)[TW-1:FW] - ts_of(0)[TW-1:FW]), 64'd1);
        chk(ts_of(0)[TW-1:FW] == n, "R2 count matches cycles since reset", 64'(ts_of(0)[TW-1:FW]), 64'(n));
        do_clear(0);
        do_clear(1);
    endtask

    task automatic t_ignore();
        logic [CW-1:0] n;
        logic [TW-1:0] held;
        // second hit while in the fine-latched state
        @(negedge clk);
        hit[1] = 1'b1; fine[FW +: FW] = 5'd20; n = mdl;
        @(negedge clk);
        fine[FW +: FW] = 5'd0;
        @(negedge clk);
        hit[1] = 1'b0;
        chk(ts_of(1) == {n, 5'd20}, "R7 hit while busy ignored", 64'(ts_of(1)), 64'({n, 5'd20}));
        held = ts_of(1);
        @(negedge clk);
        hit[1] = 1'b1; fine[FW +: FW] = 5'd3;
        repeat (3) @(negedge clk);
        hit[1] = 1'b0;
        chk(ts_of(1) == held, "R7 hit while held ignored", 64'(ts_of(1)), 64'(held));
        chk(valid[1] == 1'b1, "R7 valid stays while held", 64'(valid[1]), 64'd1);
        do_clear(1);
    endtask

    task automatic t_clear_hit();
        @(negedge clk);
        clr[2] = 1'b1; hit[2] = 1'b1; fine[2*FW +: FW] = 5'd7;
        @(negedge clk);
        clr[2] = 1'b0; hit[2] = 1'b0;
        @(negedge clk);
        chk(valid[2] == 1'b0, "R8 hit with clear ignored", 64'(valid[2]), 64'd0);
        @(negedge clk);
        chk(valid[2] == 1'b0, "R8 no late capture after clear", 64'(valid[2]), 64'd0);
    endtask

    task automatic t_indep();
        logic [CW-1:0] n;
        logic [TW-1:0] other;
        other = ts_of(3);
        do_hit(2, 5'd30, n);
        chk(ts_of(2) == {n, 5'd30}, "R10 channel 2 stamp", 64'(ts_of(2)), 64'({n, 5'd30}));
        chk(valid[3] == 1'b0 && valid[0] == 1'b0, "R10 other channels idle", 64'(valid), 64'd4);
        chk(ts_of(3) == other, "R10 other stamp untouched", 64'(ts_of(3)), 64'(other));
        do_clear(3);
        chk(valid[2] == 1'b1, "R10 clear of another channel", 64'(valid[2]), 64'd1);
        do_clear(2);
    endtask

    task automatic t_wrap();
        @(negedge clk);
        while (mdl[NW-1:0] != NW'(63)) @(negedge clk);
        n_hit = 1'b1; n_fine = 5'd0;
        @(negedge clk);
        n_hit = 1'b0;
        @(negedge clk);
        chk(n_valid && n_ts == {6'd0, 5'd0}, "R9 early hit at last count wraps", 64'(n_ts), 64'd0);
        n_clr = 1'b1;
        @(negedge clk);
        n_clr = 1'b0;
        while (mdl[NW-1:0] != NW'(63)) @(negedge clk);
        n_hit = 1'b1; n_fine = 5'd12;
        @(negedge clk);
        n_hit = 1'b0;
        @(negedge clk);
        chk(n_ts == {6'd63, 5'd12}, "R9 late hit at last count", 64'(n_ts), 64'({6'd63, 5'd12}));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_late();
        t_boundary();
        t_step();
        t_ignore();
        t_clear_hit();
        t_indep();
        t_wrap();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule